// File: doc/BRIEF.md
# Load/Store Address Conflict Matrix

This block keeps a small table of in-flight memory operations and reports, for every pair of them, whether the two might touch the same cache line. Issue logic writes one slot at a time. Each write records the operation kind (load or store), the line-select bits of the untranslated page offset, and, when a translated address is available, a short CRC digest of the translated upper bits. Retire logic frees slots with per-slot pulses. A combinational grid turns the stored slot contents into a flat N×N conflict matrix that the scheduler uses to order memory operations.

The match is conservative by design. The page-offset line bits are the same in virtual and physical form, so they are always compared exactly. Upper virtual bits never take part, because two different virtual pages can map to one physical page. Physical upper bits only narrow the match through a 5-bit digest, and only when both slots carry one. A digest collision costs a false conflict but never hides a real one.

Each slot is a two-state machine. `SLOT_FREE` is the reset state and `SLOT_LIVE` holds an operation. The `ALLOC` transition (FREE→LIVE, or LIVE→LIVE with new contents) happens on a write to the slot. The `RETIRE` transition (LIVE→FREE) happens on its clear pulse when no write targets that slot in the same cycle.

Top module: `lsc_conflict_matrix`

## Requirements
- R1: After reset every slot is free and every bit of `conflict` is 0.
- R2: When `wr_en` is high at a rising edge, slot `wr_idx` takes `wr_store`, `wr_line`, `wr_phys_ok` and the digest of `wr_phys_hi`. The matrix reflects the new contents in the cycle after that edge.
- R3: Bit i*N+j of `conflict` (i≠j) is 1 only when both slots are live, at least one holds a store (`wr_store`=1), and the key match of R4–R6 holds. Two loads never conflict.
- R4: Address bits 11..4 (`wr_line`) must be exactly equal for a conflict. No other virtual address bit takes part.
- R5: The digest is the remainder of `wr_phys_hi`·x^5 divided by x^5+x^2+1, taken over GF(2) with the most significant bit first. When both slots have `wr_phys_ok`=1, their digests must be equal for a conflict.
- R6: If either slot of a pair has `wr_phys_ok`=0, its digest is a wildcard and the pair is decided on line bits and store flags alone.
- R7: The matrix is symmetric: bit i*N+j equals bit j*N+i. Every diagonal bit i*N+i is 0.
- R8: A pulse on `clr_vec[k]` with no write to slot k in the same cycle frees slot k at that edge. From the next cycle on, every bit of row k and column k is 0.
- R9: If a clear pulse and a write target the same slot in one cycle, the write wins and the slot stays live with the new contents.
- R10: A write to a live slot replaces all of its contents. Conflicts derived from the old contents disappear in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write a slot this cycle |
| wr_idx | input | IDX_W (3) | Slot written |
| wr_store | input | 1 | 1 = store, 0 = load |
| wr_line | input | 8 | Address bits 11..4, the line index within the page |
| wr_phys_ok | input | 1 | `wr_phys_hi` holds a valid translated upper address |
| wr_phys_hi | input | PHYS_HI_W (28) | Translated address bits above the page offset |
| clr_vec | input | N_ENTRIES (8) | One retire pulse per slot |
| conflict | output | N_ENTRIES² (64) | Pair matrix, bit i*N+j for slots i and j |

## Verification
Allocation and retirement can fall in the same cycle, either on two different slots or on one slot. The directed part of the bench pulses a clear and a write to the same slot together. It also retires one slot while another is being written. The long pseudo-random sweep raises clear pulses at random beside writes, so both overlaps occur many times. The bench model applies the clear first and the write after it. Each result is judged by comparing the whole 64-bit matrix in the following cycle against that model.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    localparam int LINE_LO = 4;
    localparam int LINE_HI = 11;
    localparam int LINE_W  = LINE_HI - LINE_LO + 1;
    localparam int DIG_W   = 5;
    localparam logic [DIG_W-1:0] DIG_POLY = 5'b00101; // x^5 + x^2 + 1

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_LIVE = 1'b1
    } slot_state_t;

    typedef struct packed {
        logic              is_store;
        logic [LINE_W-1:0] line;
        logic              phys_ok;
        logic [DIG_W-1:0]  digest;
    } slot_info_t;
endpackage

// File: rtl/lsc_crc.sv
module lsc_crc #(
    parameter int IN_W  = 28,
    parameter int OUT_W = 5,
    parameter logic [OUT_W-1:0] POLY = 5'b00101
) (
    input  logic [IN_W-1:0]  data,
    output logic [OUT_W-1:0] digest
);
    logic [OUT_W-1:0] acc;
    logic             fb;

    // serial LFSR unrolled over the input, most significant bit first
    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int b = IN_W - 1; b >= 0; b--) begin
            fb  = acc[OUT_W-1] ^ data[b];
            acc = {acc[OUT_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
    end

    assign digest = acc;
endmodule

// File: rtl/lsc_slot.sv
module lsc_slot
    import lsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alloc,
    input  logic       retire,
    input  slot_info_t wr_info,
    output logic       live,
    output slot_info_t info
);
    slot_state_t state_q, state_d;
    slot_info_t  info_q;

    // next-state: ALLOC dominates RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (alloc) state_d = SLOT_LIVE;
            SLOT_LIVE: if (!alloc && retire) state_d = SLOT_FREE;
            default:   state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            info_q <= '0;
        end else if (alloc) begin
            info_q <= wr_info;
        end
    end

    // outputs
    always_comb begin
        live = (state_q == SLOT_LIVE);
        info = info_q;
    end
endmodule

// File: rtl/lsc_pair_grid.sv
module lsc_pair_grid
    import lsc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic       [N-1:0]   live,
    input  slot_info_t [N-1:0]   info,
    output logic       [N*N-1:0] hit
);
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_diag
                assign hit[i*N+j] = 1'b0;
            end else begin : g_pair
                logic both_live, any_store, line_eq, dig_ok;
                assign both_live = live[i] & live[j];
                assign any_store = info[i].is_store | info[j].is_store;
                assign line_eq   = (info[i].line == info[j].line);
                assign dig_ok    = !info[i].phys_ok || !info[j].phys_ok ||
                                   (info[i].digest == info[j].digest);
                assign hit[i*N+j] = both_live & any_store & line_eq & dig_ok;
            end
        end
    end
endmodule

// File: rtl/lsc_conflict_matrix.sv
module lsc_conflict_matrix
    import lsc_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int PHYS_HI_W = 28,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic                         wr_store,
    input  logic [LINE_W-1:0]            wr_line,
    input  logic                         wr_phys_ok,
    input  logic [PHYS_HI_W-1:0]         wr_phys_hi,
    input  logic [N_ENTRIES-1:0]         clr_vec,
    output logic [N_ENTRIES*N_ENTRIES-1:0] conflict
);
    logic [DIG_W-1:0]           wr_digest;
    slot_info_t                 wr_info;
    logic       [N_ENTRIES-1:0] alloc_vec;
    logic       [N_ENTRIES-1:0] live_vec;
    slot_info_t [N_ENTRIES-1:0] info_vec;

    lsc_crc #(
        .IN_W (PHYS_HI_W),
        .OUT_W(DIG_W),
        .POLY (DIG_POLY)
    ) u_crc (
        .data  (wr_phys_hi),
        .digest(wr_digest)
    );

    always_comb begin
        wr_info.is_store = wr_store;
        wr_info.line     = wr_line;
        wr_info.phys_ok  = wr_phys_ok;
        wr_info.digest   = wr_digest;
    end

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_slot
        assign alloc_vec[k] = wr_en && (wr_idx == IDX_W'(k));

        lsc_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .alloc  (alloc_vec[k]),
            .retire (clr_vec[k]),
            .wr_info(wr_info),
            .live   (live_vec[k]),
            .info   (info_vec[k])
        );
    end

    lsc_pair_grid #(
        .N(N_ENTRIES)
    ) u_grid (
        .live(live_vec),
        .info(info_vec),
        .hit (conflict)
    );
endmodule

// File: rtl/lsc_conflict_matrix_chk.sv
module lsc_conflict_matrix_chk #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [N-1:0]     clr_vec,
    input logic [N*N-1:0]   conflict
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (conflict == '0));

    for (genvar k = 0; k < N; k++) begin : g_k
        logic [N-1:0] col;
        for (genvar r = 0; r < N; r++) begin : g_c
            assign col[r] = conflict[r*N+k];
        end

        // R7
        diag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            conflict[k*N+k] == 1'b0);

        // R8
        retire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[k] && !(wr_en && wr_idx == IDX_W'(k)))
            |=> (conflict[k*N +: N] == '0 && col == '0));

        for (genvar j = k + 1; j < N; j++) begin : g_j
            // R7
            symmetric_chk: assert property (@(posedge clk) disable iff (!rst_n)
                conflict[k*N+j] == conflict[j*N+k]);
        end
    end
endmodule

bind lsc_conflict_matrix lsc_conflict_matrix_chk #(
    .N    (N_ENTRIES),
    .IDX_W(IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .clr_vec (clr_vec),
    .conflict(conflict)
);

// File: tb/lsc_conflict_matrix_tb.sv
module lsc_conflict_matrix_tb;
    localparam int N  = 8;
    localparam int PW = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_idx = '0;
    logic          wr_store = 1'b0;
    logic [7:0]    wr_line = '0;
    logic          wr_phys_ok = 1'b0;
    logic [PW-1:0] wr_phys_hi = '0;
    logic [N-1:0]  clr_vec = '0;
    logic [N*N-1:0] conflict;

    int checks = 0;
    int errors = 0;

    bit         m_vld [N];
    bit         m_st  [N];
    logic [7:0] m_line[N];
    bit         m_pok [N];
    logic [4:0] m_dig [N];

    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    lsc_conflict_matrix u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_store(wr_store), .wr_line(wr_line), .wr_phys_ok(wr_phys_ok),
        .wr_phys_hi(wr_phys_hi), .clr_vec(clr_vec), .conflict(conflict)
    );

    // polynomial long division of m * x^5 by x^5+x^2+1
    function automatic logic [4:0] crc_ref(logic [PW-1:0] m);
        logic [PW+4:0] v;
        v = {m, 5'b0};
        for (int i = PW + 4; i >= 5; i--) begin
            if (v[i]) v[i -: 6] = v[i -: 6] ^ 6'b100101;
        end
        return v[4:0];
    endfunction

    function automatic logic [N*N-1:0] expect_mat();
        logic [N*N-1:0] e;
        e = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (i != j && m_vld[i] && m_vld[j] && (m_st[i] || m_st[j]) &&
                    m_line[i] == m_line[j] &&
                    (!m_pok[i] || !m_pok[j] || m_dig[i] == m_dig[j]))
                    e[i*N+j] = 1'b1;
            end
        end
        return e;
    endfunction

    task automatic check_mat(string tag);
        logic [N*N-1:0] e;
        e = expect_mat();
        checks++;
        if (conflict !== e) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, conflict, e);
        end
    endtask

    task automatic set_write(int idx, bit st, logic [7:0] line, bit pok, logic [PW-1:0] ph);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_store = st; wr_line = line;
        wr_phys_ok = pok; wr_phys_hi = ph;
    endtask

    // apply model (clear first, write wins), clock, then compare
    task automatic tick(string tag);
        for (int k = 0; k < N; k++) if (clr_vec[k]) m_vld[k] = 1'b0;
        if (wr_en) begin
            m_vld[wr_idx] = 1'b1; m_st[wr_idx] = wr_store; m_line[wr_idx] = wr_line;
            m_pok[wr_idx] = wr_phys_ok; m_dig[wr_idx] = crc_ref(wr_phys_hi);
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; clr_vec = '0;
        check_mat(tag);
    endtask

    task automatic clear_all();
        clr_vec = '1;
        tick("R8 clear all");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got running exp done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [PW-1:0] pa;
        for (int k = 0; k < N; k++) begin
            m_vld[k] = 0; m_st[k] = 0; m_line[k] = 0; m_pok[k] = 0; m_dig[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (conflict !== '0) begin
            errors++;
            $display("FAIL R1 got %h exp %h", conflict, {N*N{1'b0}});
        end

        pa = 28'h0ABCDEF;
        set_write(0, 1, 8'h20, 0, '0);   tick("R2 single store");
        set_write(1, 0, 8'h20, 0, '0);   tick("R3 store-load");
        set_write(2, 0, 8'h20, 0, '0);   tick("R3 load-load none");
        set_write(3, 1, 8'h21, 0, '0);   tick("R4 line differs");
        set_write(4, 1, 8'h20, 1, pa);   tick("R6 wildcard");
        set_write(5, 0, 8'h20, 1, pa);   tick("R5 digest equal");
        set_write(6, 0, 8'h20, 1, pa ^ 28'h1); tick("R5 digest differs");
        checks++;
        if (crc_ref(pa) == crc_ref(pa ^ 28'h1)) begin
            errors++;
            $display("FAIL R5 got equal digests exp distinct");
        end
        // R7 explicit diagonal and symmetry
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                checks++;
                if ((i == j && conflict[i*N+j] !== 1'b0) ||
                    conflict[i*N+j] !== conflict[j*N+i]) begin
                    errors++;
                    $display("FAIL R7 got %b exp %b", conflict[i*N+j],
                             (i == j) ? 1'b0 : conflict[j*N+i]);
                end
            end
        end
        clr_vec = 8'h01;                    tick("R8 retire slot0");
        clr_vec = 8'h02; set_write(1, 1, 8'h20, 0, '0); tick("R9 clear+write same slot");
        clr_vec = 8'h08; set_write(7, 1, 8'h20, 1, pa); tick("R8 clear one write other");
        set_write(4, 0, 8'h55, 0, '0);      tick("R10 overwrite");
        clear_all();

        // near-exhaustive pair sweep on slots 2 and 5
        for (int c = 0; c < 64; c++) begin
            set_write(2, c[0], 8'h40, c[2], 28'h0123456);
            tick("R3 pair sweep a");
            set_write(5, c[1], c[4] ? 8'h40 : 8'h41, c[3],
                      c[5] ? 28'h0123456 : 28'h0123457);
            tick("R4 R5 R6 pair sweep b");
            clear_all();
        end

        // pseudo-random mixed traffic
        for (int s = 0; s < 3000; s++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            if (seed[31:29] != 3'b000)
                set_write(int'(seed[2:0]), seed[3], {7'h18, seed[4]}, seed[5],
                          {26'h2AAAAAA, seed[7:6]});
            if (seed[28:26] == 3'b000) clr_vec = seed[15:8];
            tick("R9 R10 random traffic");
        end
        clear_all();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule